// File: doc/BRIEF.md
# Edge-Driven Event Counter Channel

This block is a single 16-bit timer channel that counts transitions of an external signal. Two small synchronizer stages bring the external count input and the direction pin into the clock domain. Edges are then detected on the synchronized levels. Software sets the block up through a narrow register port with three registers: an 8-bit mode register, a 16-bit counter register and a 2-bit control register. The 16-bit counter register holds a reload latch and also gives access to the live count.

Each counted edge moves the counter one step, either up or down. When the counter passes its end point (0 going down, 0xFFFF going up), it either reloads from the latch or wraps freely. On that same clock the block raises a one-cycle interrupt request and, if enabled, toggles its pulse output. Counting down from reload value n divides the event rate by n+1, and counting up divides it by 0xFFFF-n+1.

An instance built with quadrature support can also decode two phase signals at four counts per phase cycle. In that mode the count input is phase A and the direction pin is phase B, and the phase order sets the direction.

Top module: `evt_counter`

## Requirements
- R1: After reset the mode, counter and control registers all read 0, and `irq`, `pulseOut` and `pulseOutEn` are low.
- R2: The counter moves only when mode bits [1:0] equal 01, mode bit 5 is 0 and the start bit (control bit 0) is 1. Otherwise edges on `evtIn` leave the count unchanged.
- R3: Mode bit 3 picks the counted edge of `evtIn`: 0 counts falling edges and 1 counts rising edges. The other edge leaves the count unchanged.
- R4: Mode bit 4 picks the direction source. When it is 0, the up flag (control bit 1, 1 = up) sets the direction. When it is 1, the synchronized `dirIn` level sets it (1 = up).
- R5: With mode bit 6 at 0 and counting down, an event at count 0 loads the reload value and pulses `irq` high for one cycle. So with reload n there is one wrap every n+1 events.
- R6: With mode bit 6 at 0 and counting up, an event at count 0xFFFF loads the reload value and pulses `irq`. So with reload n there is one wrap every 0xFFFF-n+1 events.
- R7: With mode bit 6 at 1, the counter wraps freely: 0 goes to 0xFFFF when counting down, and 0xFFFF goes to 0 when counting up. `irq` still pulses on each wrap.
- R8: A write to the counter register (select 1) always sets the reload latch. It also loads the counter only while the start bit is 0. A read at select 1 returns the live count.
- R9: `pulseOutEn` follows mode bit 2. While that bit is 1, `pulseOut` toggles on every wrap. While it is 0, `pulseOut` holds its level.
- R10: When `QUAD_EN` is 1 and mode bit 7 is 1, every single-phase change of `evtIn` (phase A) or `dirIn` (phase B) moves the count by one. The count goes up when A leads B, and mode bits 3 and 4 are ignored. When `QUAD_EN` is 0, mode bit 7 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 2 | Register select: 0 mode, 1 counter/reload, 2 control |
| busWr | input | 1 | Write strobe for the selected register |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data of the selected register (combinational) |
| evtIn | input | 1 | External event input, phase A in quadrature mode |
| dirIn | input | 1 | External direction input, phase B in quadrature mode |
| pulseOut | output | 1 | Pulse output, toggles on each wrap when enabled |
| pulseOutEn | output | 1 | High when the pin carries the pulse output |
| irq | output | 1 | One-cycle interrupt request on each wrap |

## Verification
The live count can be read back at any time, so a wrong count, direction or edge choice appears on `busRdata` at the first read after the third clock edge following the input change. Faults in the reload latch or the wrap logic stay hidden until the next wrap. At that wrap they appear all at once as a wrong count, a missing or extra `irq` pulse, and a `pulseOut` level that does not match. The directed tests therefore drive each case through at least one full wrap. A second instance built without quadrature support receives the same stimulus, which shows that mode bit 7 is ignored there.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam logic [1:0] SEL_MODE  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;

  localparam int MB_PULSE = 2;
  localparam int MB_EDGE  = 3;
  localparam int MB_DIRSRC = 4;
  localparam int MB_RSVD  = 5;
  localparam int MB_FREE  = 6;
  localparam int MB_QUAD  = 7;

  typedef struct packed {
    logic step;
    logic up;
    logic loadCnt;
    logic loadReload;
    logic freeRun;
    logic pulseEn;
  } ctrlStb_t;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= din;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= stage[g-1];
      end
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/evt_ctrl.sv
module evt_ctrl
  import evt_pkg::*;
#(
  parameter bit QUAD_EN     = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] busSel,
  input  logic       busWr,
  input  logic [7:0] busWdata,
  input  logic       evtIn,
  input  logic       dirIn,
  output logic [7:0] modeReg,
  output logic       startBit,
  output logic       upFlag,
  output ctrlStb_t   stb
);
  logic [1:0] syncOut;
  logic evtS, dirS, evtP, dirP;

  evt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .din({dirIn, evtIn}), .dout(syncOut)
  );
  assign evtS = syncOut[0];
  assign dirS = syncOut[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtP <= 1'b0;
      dirP <= 1'b0;
    end else begin
      evtP <= evtS;
      dirP <= dirS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= '0;
      startBit <= 1'b0;
      upFlag   <= 1'b0;
    end else if (busWr) begin
      if (busSel == SEL_MODE) modeReg <= busWdata;
      if (busSel == SEL_CTRL) begin
        startBit <= busWdata[0];
        upFlag   <= busWdata[1];
      end
    end
  end

  logic countOn, quadOn;
  logic normHit, normUp, quadHit, quadUp;

  assign countOn = (modeReg[1:0] == 2'b01) && !modeReg[MB_RSVD] && startBit;
  assign quadOn  = QUAD_EN && modeReg[MB_QUAD];

  assign normHit = modeReg[MB_EDGE] ? (evtS & ~evtP) : (~evtS & evtP);
  assign normUp  = modeReg[MB_DIRSRC] ? dirS : upFlag;
  assign quadHit = (evtS ^ evtP) ^ (dirS ^ dirP);
  assign quadUp  = evtS ^ dirP;

  always_comb begin
    stb            = '0;
    stb.step       = countOn && (quadOn ? quadHit : normHit);
    stb.up         = quadOn ? quadUp : normUp;
    stb.loadCnt    = busWr && (busSel == SEL_COUNT) && !startBit;
    stb.loadReload = busWr && (busSel == SEL_COUNT);
    stb.freeRun    = modeReg[MB_FREE];
    stb.pulseEn    = modeReg[MB_PULSE];
  end
endmodule

// File: rtl/evt_datapath.sv
module evt_datapath
  import evt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStb_t      stb,
  input  logic [CW-1:0] wrData,
  output logic [CW-1:0] countVal,
  output logic          pulseOut,
  output logic          irq
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
  localparam logic [CW-1:0] CNT_ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] reloadVal;
  logic          atEnd;

  assign atEnd = stb.up ? (countVal == CNT_MAX) : (countVal == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal  <= '0;
      reloadVal <= '0;
      pulseOut  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (stb.loadReload) reloadVal <= wrData;
      if (stb.loadCnt) begin
        countVal <= wrData;
      end else if (stb.step) begin
        if (atEnd) begin
          irq <= 1'b1;
          if (stb.pulseEn) pulseOut <= ~pulseOut;
          if (stb.freeRun) countVal <= stb.up ? '0 : CNT_MAX;
          else             countVal <= reloadVal;
        end else begin
          countVal <= stb.up ? countVal + CNT_ONE : countVal - CNT_ONE;
        end
      end
    end
  end
endmodule

// File: rtl/evt_counter.sv
module evt_counter
  import evt_pkg::*;
#(
  parameter bit QUAD_EN     = 1'b1,
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    busSel,
  input  logic          busWr,
  input  logic [CW-1:0] busWdata,
  output logic [CW-1:0] busRdata,
  input  logic          evtIn,
  input  logic          dirIn,
  output logic          pulseOut,
  output logic          pulseOutEn,
  output logic          irq
);
  ctrlStb_t      stb;
  logic [7:0]    modeReg;
  logic          startBit, upFlag;
  logic [CW-1:0] countVal;

  evt_ctrl #(.QUAD_EN(QUAD_EN), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busWdata(busWdata[7:0]), .evtIn(evtIn), .dirIn(dirIn),
    .modeReg(modeReg), .startBit(startBit), .upFlag(upFlag), .stb(stb)
  );

  evt_datapath #(.CW(CW)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWdata),
    .countVal(countVal), .pulseOut(pulseOut), .irq(irq)
  );

  assign pulseOutEn = modeReg[MB_PULSE];

  always_comb begin
    case (busSel)
      SEL_MODE:  busRdata = {{(CW-8){1'b0}}, modeReg};
      SEL_COUNT: busRdata = countVal;
      SEL_CTRL:  busRdata = {{(CW-2){1'b0}}, upFlag, startBit};
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/evt_counter_chk.sv
module evt_counter_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          irq,
  input logic          pulseOut,
  input logic          pulseOutEn,
  input logic          step,
  input logic          loadCnt,
  input logic [CW-1:0] countVal
);
  assert_count_holds_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!step && !loadCnt) |=> $stable(countVal));

  assert_step_by_one_R4: assert property (@(posedge clk) disable iff (!rstN)
    (step && !loadCnt) |=> (irq || countVal == CW'($past(countVal) + 1'b1)
                                || countVal == CW'($past(countVal) - 1'b1)));

  assert_irq_from_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(step && !loadCnt));

  assert_load_not_with_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(step && loadCnt));

  assert_pulse_only_on_wrap_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pulseOut) |-> irq);

  assert_pulse_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    !pulseOutEn |=> $stable(pulseOut));
endmodule

bind evt_counter evt_counter_chk #(.CW(CW)) chk (
  .clk(clk), .rstN(rstN), .irq(irq), .pulseOut(pulseOut),
  .pulseOutEn(pulseOutEn), .step(stb.step), .loadCnt(stb.loadCnt),
  .countVal(countVal)
);

// File: tb/evt_counter_test.sv
module evt_counter_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busSel = 2'd0;
  logic        busWr = 1'b0;
  logic [15:0] busWdata = 16'h0;
  logic [15:0] busRdata, rdNq;
  logic        evtIn = 1'b0, dirIn = 1'b0;
  logic        pulseOut, pulseOutEn, irq;
  logic        pulseNq, pulseEnNq, irqNq;
  int checks = 0, errors = 0, irqCnt = 0;

  always #2.5 clk = ~clk;

  evt_counter #(.QUAD_EN(1'b1)) uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .evtIn(evtIn), .dirIn(dirIn), .pulseOut(pulseOut),
    .pulseOutEn(pulseOutEn), .irq(irq));

  evt_counter #(.QUAD_EN(1'b0)) uutNoQuad (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busWdata(busWdata),
    .busRdata(rdNq), .evtIn(evtIn), .dirIn(dirIn), .pulseOut(pulseNq),
    .pulseOutEn(pulseEnNq), .irq(irqNq));

  always @(negedge clk) if (irq) irqCnt++;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    busSel = sel; busWdata = data; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [15:0] val);
    @(negedge clk);
    busSel = sel;
    #1 val = busRdata;
  endtask

  task automatic setIn(input logic e, input logic d);
    @(negedge clk);
    evtIn = e; dirIn = d;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse(input logic d);
    setIn(1'b0, d); setIn(1'b1, d); setIn(1'b0, d);
  endtask

  task automatic checkCount(input string req, input logic [15:0] exp);
    logic [15:0] v;
    rd(2'd1, v);
    check(req, v, exp);
  endtask

  task automatic testReset();
    logic [15:0] v;
    rd(2'd0, v); check("R1 mode", v, 16'h0);
    rd(2'd1, v); check("R1 count", v, 16'h0);
    rd(2'd2, v); check("R1 ctrl", v, 16'h0);
    check("R1 outputs", {13'd0, irq, pulseOut, pulseOutEn}, 16'h0);
  endtask

  task automatic testEnable();
    wr(2'd2, 16'h0); wr(2'd1, 16'd5);
    checkCount("R8 load stopped", 16'd5);
    wr(2'd0, 16'h08); wr(2'd2, 16'h1);
    pulse(1'b0); checkCount("R2 mode 00 ignored", 16'd5);
    wr(2'd0, 16'h29);
    pulse(1'b0); checkCount("R2 bit5 ignored", 16'd5);
    wr(2'd0, 16'h09); wr(2'd2, 16'h0);
    pulse(1'b0); checkCount("R2 stopped ignored", 16'd5);
    wr(2'd2, 16'h1);
    pulse(1'b0); checkCount("R2 enabled counts", 16'd4);
  endtask

  task automatic testEdge();
    wr(2'd2, 16'h0); wr(2'd0, 16'h09); wr(2'd1, 16'd10); wr(2'd2, 16'h1);
    setIn(1'b1, 1'b0); checkCount("R3 rising counted", 16'd9);
    setIn(1'b0, 1'b0); checkCount("R3 falling ignored", 16'd9);
    wr(2'd0, 16'h01);
    setIn(1'b1, 1'b0); checkCount("R3 rising ignored", 16'd9);
    setIn(1'b0, 1'b0); checkCount("R3 falling counted", 16'd8);
  endtask

  task automatic testDirection();
    wr(2'd0, 16'h09); wr(2'd2, 16'h3);
    pulse(1'b0); checkCount("R4 flag up", 16'd9);
    wr(2'd0, 16'h19);
    pulse(1'b0); checkCount("R4 pin down", 16'd8);
    pulse(1'b1); checkCount("R4 pin up", 16'd9);
  endtask

  task automatic testDownReload();
    wr(2'd2, 16'h0); wr(2'd0, 16'h09); wr(2'd1, 16'd2); wr(2'd2, 16'h1);
    irqCnt = 0;
    pulse(1'b0); pulse(1'b0);
    checkCount("R5 reaches zero", 16'd0);
    check("R5 no irq yet", 16'(irqCnt), 16'd0);
    pulse(1'b0);
    checkCount("R5 reload", 16'd2);
    check("R5 one irq", 16'(irqCnt), 16'd1);
    pulse(1'b0); pulse(1'b0); pulse(1'b0);
    check("R5 period n+1", 16'(irqCnt), 16'd2);
  endtask

  task automatic testUpReload();
    wr(2'd2, 16'h0); wr(2'd1, 16'hFFFD); wr(2'd2, 16'h3);
    irqCnt = 0;
    pulse(1'b0); pulse(1'b0);
    checkCount("R6 reaches max", 16'hFFFF);
    pulse(1'b0);
    checkCount("R6 reload", 16'hFFFD);
    check("R6 one irq", 16'(irqCnt), 16'd1);
    pulse(1'b0); pulse(1'b0); pulse(1'b0);
    check("R6 period", 16'(irqCnt), 16'd2);
  endtask

  task automatic testFreeRun();
    wr(2'd2, 16'h0); wr(2'd0, 16'h49); wr(2'd1, 16'd0); wr(2'd2, 16'h1);
    irqCnt = 0;
    pulse(1'b0); checkCount("R7 down wraps to max", 16'hFFFF);
    check("R7 irq down", 16'(irqCnt), 16'd1);
    wr(2'd2, 16'h3);
    pulse(1'b0); checkCount("R7 up wraps to zero", 16'h0000);
    check("R7 irq up", 16'(irqCnt), 16'd2);
  endtask

  task automatic testLiveWrite();
    wr(2'd2, 16'h0); wr(2'd0, 16'h09); wr(2'd1, 16'd1); wr(2'd2, 16'h1);
    wr(2'd1, 16'd7);
    checkCount("R8 running write keeps count", 16'd1);
    pulse(1'b0); pulse(1'b0);
    checkCount("R8 new reload used", 16'd7);
  endtask

  task automatic testPulse();
    logic p0;
    wr(2'd2, 16'h0); wr(2'd0, 16'h0D);
    #1 check("R9 enable high", {15'd0, pulseOutEn}, 16'd1);
    wr(2'd1, 16'd0); wr(2'd2, 16'h1);
    p0 = pulseOut;
    pulse(1'b0);
    check("R9 toggled", {15'd0, pulseOut}, {15'd0, ~p0});
    wr(2'd0, 16'h09);
    #1 check("R9 enable low", {15'd0, pulseOutEn}, 16'd0);
    irqCnt = 0;
    pulse(1'b0);
    check("R9 wrap happened", 16'(irqCnt), 16'd1);
    check("R9 held", {15'd0, pulseOut}, {15'd0, ~p0});
  endtask

  task automatic testQuad();
    logic [15:0] v;
    setIn(1'b0, 1'b0);
    wr(2'd2, 16'h0); wr(2'd0, 16'h81); wr(2'd1, 16'd100); wr(2'd2, 16'h1);
    setIn(1'b1, 1'b0); checkCount("R10 first step", 16'd101);
    setIn(1'b1, 1'b1); setIn(1'b0, 1'b1); setIn(1'b0, 1'b0);
    checkCount("R10 forward x4", 16'd104);
    rd(2'd1, v); v = rdNq; check("R10 no-quad normal", v, 16'd99);
    setIn(1'b0, 1'b1); setIn(1'b1, 1'b1); setIn(1'b1, 1'b0); setIn(1'b0, 1'b0);
    checkCount("R10 reverse x4", 16'd100);
    rd(2'd1, v); v = rdNq; check("R10 no-quad reverse", v, 16'd98);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEnable();
    testEdge();
    testDirection();
    testDownReload();
    testUpReload();
    testFreeRun();
    testLiveWrite();
    testPulse();
    testQuad();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule